// File: doc/BRIEF.md
# Programmable Clock Output Selector

This block drives one clock output from a choice of three internal clocks: a free-running RC oscillator clock, a crystal clock passed through an integer divider, and a clock recovered from incoming data. Three small control registers set the behaviour. One holds an active-low output enable. One holds a two-bit source select, which includes an automatic mode and an off setting. One holds a two-bit divide code for the crystal path. Software writes them through a simple address, data and strobe port, and reads them back through a combinational read port.

The divider produces ratios of 1, 2, 3 and 4. The odd ratio uses a falling-edge stage, so every ratio has a 50% duty cycle. A change of source, divide ratio or enable passes through a glitch-free switch. The old clock is blocked on its own falling edge. The new clock is admitted on its own falling edge, and only after the old one is fully blocked. The divider takes a new ratio only while the crystal path is blocked. The output therefore never shows a runt pulse.

In automatic mode the recovered clock has priority while the recovery circuit reports lock. The divided crystal clock is next, if the crystal reports ready. The RC clock is the fallback.

Top module: `clkout_sel`

## Requirements
- R1: After reset the output is enabled, the select field is automatic (00) and the divide code is 00 (divide by 4). All three registers read back 0x00.
- R2: Only the mapped fields are stored: bit 7 at address 0x0C (enable), bits 5:4 at 0x0D (select) and bits 1:0 at 0x0E (divide). Every other bit of these registers reads as zero. Any other address reads 0x00.
- R3: A write takes place on a rising `clk` edge while `wr_en` is high. The written field is visible on `rd_data` from the next cycle.
- R4: Select code 01 outputs the RC clock, 10 outputs the divided crystal clock, and 11 holds the output low.
- R5: Divide code 00 divides the crystal clock by 4, 01 by 3, 10 by 2 and 11 by 1.
- R6: Every divide ratio, including 3, gives a high phase of half the output period, to within the resolution of one crystal half period.
- R7: In automatic mode (select 00) the output is the recovered clock when `rec_locked` is high. When it is low, the output is the divided crystal clock if `xtal_ready` is high, and the RC clock otherwise.
- R8: The enable bit is active low. With bit 7 of 0x0C set to 1, the output is held low whatever the select field.
- R9: No high or low phase of `clk_out` is shorter than the shortest legal phase of any selectable clock, across all switches.
- R10: At most one source path is open at any time.
- R11: The applied divide ratio changes only while the crystal path is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| rc_clk | input | 1 | RC oscillator clock |
| xtal_clk | input | 1 | Crystal oscillator clock |
| rec_clk | input | 1 | Recovered data clock |
| rec_locked | input | 1 | Clock recovery reports lock |
| xtal_ready | input | 1 | Crystal oscillator reports stable |
| clk_out | output | 1 | Selected, divided and gated clock |

## Verification
The bound checker watches, on every cycle, that the source paths stay mutually exclusive. It also checks that a select write lands in the field on the next cycle, that unmapped bits read as zero, and that the divider changes ratio only while the crystal path is closed. The bench measures the output itself, so only its scenarios show the period and duty cycle for each source and ratio, the automatic priority under the lock and ready inputs, low output when disabled or off, and the absence of runt phases across switches.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
   localparam int NUM_SRC  = 3;
   localparam int LANE_RC  = 0;
   localparam int LANE_XT  = 1;
   localparam int LANE_RD  = 2;

   localparam int EN_BIT   = 7;
   localparam int SEL_LSB  = 4;
   localparam int DIV_LSB  = 0;
   localparam int SEL_W    = 2;

   typedef enum logic [SEL_W-1:0] {
      SRC_AUTO = 2'b00,
      SRC_RC   = 2'b01,
      SRC_XTAL = 2'b10,
      SRC_NONE = 2'b11
   } src_sel_e;
endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/1ps
module clkout_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkout_regs.sv
`timescale 1ns/1ps
module clkout_regs #(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 8,
   parameter int              DIV_W    = 2,
   parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h0C,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h0D,
   parameter logic [ADDR_W-1:0] DIV_ADDR = 8'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              en_n,
   output logic [clkout_pkg::SEL_W-1:0] sel,
   output logic [DIV_W-1:0]  div
);
   import clkout_pkg::*;

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_n <= 1'b0;
         sel  <= SRC_AUTO;
         div  <= '0;
      end else if (wr_en) begin
         if (wr_addr == EN_ADDR)  en_n <= wr_data[EN_BIT];
         if (wr_addr == SEL_ADDR) sel  <= wr_data[SEL_LSB +: SEL_W];
         if (wr_addr == DIV_ADDR) div  <= wr_data[DIV_LSB +: DIV_W];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == EN_ADDR)  rd_data[EN_BIT]            = en_n;
      if (rd_addr == SEL_ADDR) rd_data[SEL_LSB +: SEL_W]  = sel;
      if (rd_addr == DIV_ADDR) rd_data[DIV_LSB +: DIV_W]  = div;
   end
endmodule

// File: rtl/clkout_xdiv.sv
`timescale 1ns/1ps
module clkout_xdiv #(
   parameter int DIV_W  = 2,
   parameter int STAGES = 2
) (
   input  logic             xtal_clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_cfg,
   input  logic             path_closed,
   output logic [DIV_W-1:0] div_applied,
   output logic             xdiv_clk
);
   localparam int CNT_W = DIV_W + 1;
   localparam logic [CNT_W-1:0] MAX_RATIO = CNT_W'(1 << DIV_W);

   logic [DIV_W-1:0] cfg_s;
   logic             closed_s;
   logic [CNT_W-1:0] cnt, nxt, ratio, half;
   logic             ph_p, ph_n, odd;

   clkout_sync #(.W(DIV_W), .STAGES(STAGES)) u_cfg_sync (
      .clk(xtal_clk), .rst_n(rst_n), .d(div_cfg), .q(cfg_s));
   clkout_sync #(.W(1), .STAGES(STAGES)) u_closed_sync (
      .clk(xtal_clk), .rst_n(rst_n), .d(path_closed), .q(closed_s));

   assign ratio = MAX_RATIO - CNT_W'(div_applied);
   assign half  = ratio >> 1;
   assign odd   = ratio[0];
   assign nxt   = (cnt == ratio - 1'b1) ? '0 : cnt + 1'b1;

   always_ff @(posedge xtal_clk or negedge rst_n) begin
      if (!rst_n) begin
         div_applied <= '0;
         cnt         <= '0;
         ph_p        <= 1'b0;
      end else if (closed_s && (cfg_s != div_applied)) begin
         div_applied <= cfg_s;
         cnt         <= '0;
         ph_p        <= 1'b0;
      end else begin
         cnt  <= nxt;
         ph_p <= (nxt < half);
      end
   end

   always_ff @(negedge xtal_clk or negedge rst_n) begin
      if (!rst_n) ph_n <= 1'b0;
      else        ph_n <= ph_p & odd;
   end

   assign xdiv_clk = (ratio == CNT_W'(1)) ? xtal_clk : (ph_p | ph_n);
endmodule

// File: rtl/clkout_gfmux.sv
`timescale 1ns/1ps
module clkout_gfmux #(
   parameter int N_SRC = 3
) (
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   input  logic [N_SRC-1:0] req,
   output logic [N_SRC-1:0] lane_on,
   output logic             clk_o
);
   logic [N_SRC-1:0] arm, pass, blk;

   always_comb begin
      blk = '0;
      for (int i = 0; i < N_SRC; i++)
         for (int j = 0; j < N_SRC; j++)
            if (j != i) blk[i] = blk[i] | arm[j] | pass[j];
   end

   for (genvar g = 0; g < N_SRC; g++) begin : g_lane
      logic arm_q, pass_q;
      always_ff @(posedge src[g] or negedge rst_n) begin
         if (!rst_n) arm_q <= 1'b0;
         else        arm_q <= req[g] & ~blk[g];
      end
      always_ff @(negedge src[g] or negedge rst_n) begin
         if (!rst_n) pass_q <= 1'b0;
         else        pass_q <= arm_q;
      end
      assign arm[g]  = arm_q;
      assign pass[g] = pass_q;
   end

   assign lane_on = pass;
   assign clk_o   = |(src & pass);
endmodule

// File: rtl/clkout_sel.sv
`timescale 1ns/1ps
module clkout_sel #(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 8,
   parameter int              DIV_W    = 2,
   parameter int              STAGES   = 2,
   parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h0C,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h0D,
   parameter logic [ADDR_W-1:0] DIV_ADDR = 8'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rc_clk,
   input  logic              xtal_clk,
   input  logic              rec_clk,
   input  logic              rec_locked,
   input  logic              xtal_ready,
   output logic              clk_out
);
   import clkout_pkg::*;

   if (DATA_W < EN_BIT + 1) begin : g_bad_data_w
      $error("DATA_W must hold the enable bit");
   end
   if (DIV_W != 2) begin : g_bad_div_w
      $error("DIV_W must be 2 (ratios 1 to 4)");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   logic                cfg_en_n;
   logic [SEL_W-1:0]    cfg_sel;
   logic [DIV_W-1:0]    cfg_div;
   logic [DIV_W-1:0]    div_applied, applied_s;
   logic [1:0]          stat_s;
   logic                xdiv_clk;
   logic [NUM_SRC-1:0]  req, lane_on, src;
   int                  pick;

   clkout_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
      .EN_ADDR(EN_ADDR), .SEL_ADDR(SEL_ADDR), .DIV_ADDR(DIV_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .en_n(cfg_en_n), .sel(cfg_sel), .div(cfg_div));

   clkout_sync #(.W(2), .STAGES(STAGES)) u_stat_sync (
      .clk(clk), .rst_n(rst_n), .d({rec_locked, xtal_ready}), .q(stat_s));
   clkout_sync #(.W(DIV_W), .STAGES(STAGES)) u_appl_sync (
      .clk(clk), .rst_n(rst_n), .d(div_applied), .q(applied_s));

   clkout_xdiv #(.DIV_W(DIV_W), .STAGES(STAGES)) u_xdiv (
      .xtal_clk(xtal_clk), .rst_n(rst_n), .div_cfg(cfg_div),
      .path_closed(~lane_on[LANE_XT]), .div_applied(div_applied),
      .xdiv_clk(xdiv_clk));

   always_comb begin
      case (src_sel_e'(cfg_sel))
         SRC_RC:   pick = LANE_RC;
         SRC_XTAL: pick = LANE_XT;
         SRC_AUTO: pick = stat_s[1] ? LANE_RD : (stat_s[0] ? LANE_XT : LANE_RC);
         default:  pick = LANE_RC;
      endcase
      req = '0;
      if (!cfg_en_n && (cfg_sel != SRC_NONE)) begin
         req[pick] = 1'b1;
         if (pick == LANE_XT && applied_s != cfg_div) req = '0;
      end
   end

   always_comb begin
      src          = '0;
      src[LANE_RC] = rc_clk;
      src[LANE_XT] = xdiv_clk;
      src[LANE_RD] = rec_clk;
   end

   clkout_gfmux #(.N_SRC(NUM_SRC)) u_mux (
      .rst_n(rst_n), .src(src), .req(req), .lane_on(lane_on), .clk_o(clk_out));
endmodule

// File: rtl/clkout_sel_chk.sv
`timescale 1ns/1ps
module clkout_sel_chk #(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 8,
   parameter int              DIV_W    = 2,
   parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h0C,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h0D
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [1:0]        cfg_sel,
   input logic [2:0]        lane_on,
   input logic [DIV_W-1:0]  div_applied
);
   import clkout_pkg::*;

   localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << EN_BIT;

   a_r10_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_on));

   a_r3_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SEL_ADDR) |=> (cfg_sel == $past(wr_data[SEL_LSB +: SEL_W])));

   a_r2_en_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == EN_ADDR) |-> ((rd_data & ~EN_MASK) == '0));

   a_r11_div_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_applied) |-> !lane_on[LANE_XT]);
endmodule

bind clkout_sel clkout_sel_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
   .EN_ADDR(EN_ADDR), .SEL_ADDR(SEL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .cfg_sel(cfg_sel), .lane_on(lane_on), .div_applied(div_applied));

// File: tb/tb_clkout_sel.sv
`timescale 1ns/1ps
module tb_clkout_sel;
   logic       clk = 0, rst_n = 0;
   logic       wr_en = 0;
   logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
   logic [7:0] rd_data;
   logic       rc_clk = 0, xtal_clk = 0, rec_clk = 0;
   logic       rec_locked = 0, xtal_ready = 0;
   logic       clk_out;

   int n_chk = 0, n_bad = 0, runts = 0;
   bit done = 0, armed = 0;
   realtime t_rise = 0, t_fall = 0;

   localparam real T_XT = 8.0, T_RC = 30.0, T_RD = 14.0;

   always #5  clk = ~clk;
   always #4  xtal_clk = ~xtal_clk;
   always #15 rc_clk = ~rc_clk;
   always #7  rec_clk = ~rec_clk;

   clkout_sel dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .rc_clk(rc_clk), .xtal_clk(xtal_clk), .rec_clk(rec_clk),
      .rec_locked(rec_locked), .xtal_ready(xtal_ready), .clk_out(clk_out));

   // R9 monitor: no phase shorter than the crystal half period (4 ns)
   always @(posedge clk_out) begin
      if (armed && ($realtime - t_fall) < 3.9) runts++;
      t_rise = $realtime;
   end
   always @(negedge clk_out) begin
      if (armed && ($realtime - t_rise) < 3.9) runts++;
      t_fall = $realtime;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input real act, input real exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   function automatic real exp_per(int en_n, int sel, int dv, int lk, int rdy);
      real x;
      x = T_XT * (4 - dv);
      if (en_n != 0 || sel == 3) return 0.0;
      if (sel == 1) return T_RC;
      if (sel == 2) return x;
      if (lk != 0) return T_RD;
      if (rdy != 0) return x;
      return T_RC;
   endfunction

   task automatic measure(output int rises, output real per, output real hi,
                          output logic lvl);
      realtime r_prev, r_last;
      logic prev;
      r_prev = -1; r_last = -1; hi = 0; rises = 0;
      #0.1;
      prev = clk_out;
      for (int k = 0; k < 2400; k++) begin
         #0.25;
         if (clk_out && !prev) begin
            rises++; r_prev = r_last; r_last = $realtime;
         end
         if (!clk_out && prev && r_last >= 0) hi = $realtime - r_last;
         prev = clk_out;
      end
      per = (r_prev >= 0) ? (r_last - r_prev) : 0.0;
      lvl = clk_out;
   endtask

   task automatic check_out(input string req, input real ep);
      int rises; real per, hi; logic lvl;
      repeat (150) @(negedge clk);
      measure(rises, per, hi, lvl);
      if (ep == 0.0) begin
         check(rises == 0 && lvl == 1'b0, req, "output held low (rising edges)",
               real'(rises), 0.0);
      end else begin
         check(per > ep - 0.3 && per < ep + 0.3, req, "period", per, ep);
         check(hi > ep / 2 - 0.3 && hi < ep / 2 + 0.3, req, "high time", hi, ep / 2);
      end
   endtask

   task automatic apply(input int en_n, input int sel, input int dv,
                        input int lk, input int rdy);
      rec_locked = lk[0]; xtal_ready = rdy[0];
      wr(8'h0E, 8'(($urandom & 8'hFC) | dv));
      wr(8'h0D, 8'(($urandom & 8'hCF) | (sel << 4)));
      wr(8'h0C, 8'(($urandom & 8'h7F) | (en_n << 7)));
   endtask

   initial begin
      logic [7:0] d;
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(8'h0C, d); check(d == 8'h00, "R1", "reset enable reg", real'(d), 0.0);
      rd(8'h0D, d); check(d == 8'h00, "R1", "reset select reg", real'(d), 0.0);
      rd(8'h0E, d); check(d == 8'h00, "R1", "reset divide reg", real'(d), 0.0);
      armed = 1;
      // R1/R7: auto, nothing locked or ready -> RC clock
      check_out("R1", T_RC);

      // R2/R3 unused bits and write port
      wr(8'h0C, 8'hFF); rd(8'h0C, d); check(d == 8'h80, "R2", "en reg 0xFF", real'(d), 128.0);
      check_out("R8", 0.0);
      wr(8'h0C, 8'h7F); rd(8'h0C, d); check(d == 8'h00, "R2", "en reg 0x7F", real'(d), 0.0);
      wr(8'h0D, 8'hFF); rd(8'h0D, d); check(d == 8'h30, "R3", "sel reg 0xFF", real'(d), 48.0);
      check_out("R4", 0.0);
      wr(8'h0E, 8'hFE); rd(8'h0E, d); check(d == 8'h02, "R2", "div reg 0xFE", real'(d), 2.0);
      rd(8'h0F, d); check(d == 8'h00, "R2", "unmapped address", real'(d), 0.0);

      // R5/R6 directed: every ratio
      for (int dv = 0; dv < 4; dv++) begin
         apply(0, 2, dv, 0, 0);
         check_out("R5", exp_per(0, 2, dv, 0, 0));
      end
      apply(0, 2, 1, 0, 0);
      check_out("R6", T_XT * 3);
      // R7 auto priorities
      apply(0, 0, 2, 1, 1); check_out("R7", T_RD);
      apply(0, 0, 2, 0, 1); check_out("R7", T_XT * 2);
      apply(0, 0, 2, 0, 0); check_out("R7", T_RC);
      apply(0, 1, 0, 1, 1); check_out("R4", T_RC);

      // randomized sweep
      for (int it = 0; it < 24; it++) begin
         int en_n, sel, dv, lk, rdy;
         en_n = (($urandom % 5) == 0) ? 1 : 0;
         sel = $urandom % 4; dv = $urandom % 4;
         lk = $urandom % 2; rdy = $urandom % 2;
         apply(en_n, sel, dv, lk, rdy);
         check_out((en_n != 0) ? "R8" : ((sel == 0) ? "R7" : "R5"),
                   exp_per(en_n, sel, dv, lk, rdy));
      end

      check(runts == 0, "R9", "runt phases on clk_out", real'(runts), 0.0);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule